// File: doc/BRIEF.md
# Double-Buffered Four-Channel Converter Code Bank

This block holds the codes for four output converters. Each channel has a staging (input) register and a live (output) register. The serial front end writes a 12-bit code to one channel, or to all four at once, and the live registers follow in one of two ways:

- **Deferred:** a falling edge on the active-low load line copies every staging register to its live register in the same clock.
- **Immediate:** while the load line is held low, a write goes straight to the live register of each channel it addresses.

An active-low clear line empties both register sets. While the clear line is low, the load line has no effect.

The load and clear lines are asynchronous. Each passes through a two-stage synchronizer into the system clock domain, and its falling edge is detected after the synchronizer. Each live register drives a one-cycle pulse whenever it is loaded by a load event, so that update timing can be observed. The four live codes leave the block packed into one vector, with channel k in bits [12k+11:12k].

Top module: `chan_code_bank`

## Requirements
- R1: After reset, all four staging registers and all four live registers hold 0x000, and every update pulse is low.
- R2: A write to address k+1 (001 to 100) loads only the staging register of channel k. While the load line stays high, no live register changes.
- R3: A write to address 101 loads the same code into all four staging registers.
- R4: Writes to addresses 000, 110 and 111 change no register.
- R5: A falling edge on load_n copies all four staging registers into their live registers together. The live codes change on the third rising clock edge after load_n falls, and not before.
- R6: When a write is presented while the synchronized load line is low, the live register of each addressed channel takes the written code on the same clock edge as its staging register.
- R7: A falling edge on clear_n sets every staging and live register to 0x000 on the third rising clock edge after it.
- R8: While the synchronized clear line is low, load edges and load levels cause no live-register update. Writes still reach the staging registers and appear after clear is released and a load edge follows.
- R9: A write presented on the same clock edge at which the clear takes effect is lost. The clear wins.
- R10: upd_pulse[k] is high for exactly one cycle, in the cycle after live register k is loaded by a load edge or by an immediate write. It stays low when a clear empties the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | One-cycle write strobe from the serial decoder |
| wr_addr | input | 3 | Write address: 001 to 100 select a channel, 101 selects all channels |
| wr_data | input | 12 | Code to write |
| load_n | input | 1 | Asynchronous active-low load line |
| clear_n | input | 1 | Asynchronous active-low clear line |
| code_out | output | 48 | Live codes; channel k in bits [12k+11:12k] |
| upd_pulse | output | 4 | Per-channel one-cycle live-register update pulse |

## Verification
The hardest situation to reach from the ports is a write landing exactly on the clock edge where a clear takes effect. The clear passes through two synchronizer stages, so that edge is invisible at the pins. The bench lowers clear_n at a falling clock edge, counts two rising edges, and presents the write strobe across the third. It then releases the clear and pulses the load line, which exposes the lost write as a zero live code. Staged writes made while the clear is held low are brought out the same way, through a later load edge.

// File: rtl/bank_pkg.sv
package bank_pkg;

  // Control events decoded once in the top and shared by every channel slice.
  typedef struct packed {
    logic clr_evt;   // clear has just taken effect: empty both registers
    logic load_evt;  // load edge seen while clear inactive: copy staging to live
    logic imm_ok;    // load level low while clear inactive: writes go live at once
  } bank_ctl_t;

endpackage

// File: rtl/sync_edge.sv
module sync_edge #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic lvl,
  output logic fell
);

  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;
  logic              prev_q;

  generate
    if (STAGES == 1) begin : g_single
      always_comb sh_d = async_in;
    end else begin : g_chain
      always_comb sh_d = {sh_q[STAGES-2:0], async_in};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= {STAGES{RST_VAL}};
      prev_q <= RST_VAL;
    end else begin
      sh_q   <= sh_d;
      prev_q <= sh_q[STAGES-1];
    end
  end

  assign lvl  = sh_q[STAGES-1];
  assign fell = prev_q & ~sh_q[STAGES-1];

endmodule

// File: rtl/wr_decode.sv
module wr_decode #(
  parameter int NCH        = 4,
  parameter int AW         = 3,
  parameter int CH_BASE    = 1,
  parameter int BCAST_ADDR = 5
) (
  input  logic           wr_en,
  input  logic [AW-1:0]  wr_addr,
  output logic [NCH-1:0] hit
);

  localparam logic [AW-1:0] BCAST = AW'(BCAST_ADDR);

  logic bcast_sel;
  assign bcast_sel = (wr_addr == BCAST);

  generate
    for (genvar k = 0; k < NCH; k++) begin : g_hit
      localparam logic [AW-1:0] MY_ADDR = AW'(CH_BASE + k);
      assign hit[k] = wr_en & ((wr_addr == MY_ADDR) | bcast_sel);
    end
  endgenerate

endmodule

// File: rtl/chan_slice.sv
module chan_slice
  import bank_pkg::*;
#(
  parameter int DW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  bank_ctl_t     ctl,
  input  logic          wr_hit,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] code,
  output logic          upd
);

  logic [DW-1:0] in_q,  in_d;
  logic [DW-1:0] out_q, out_d;
  logic          upd_q, upd_d;
  logic          in_en, out_en;

  // Next-state: clear dominates; a load edge forwards a same-cycle write.
  always_comb begin
    in_en  = ctl.clr_evt | wr_hit;
    in_d   = ctl.clr_evt ? '0 : wr_data;
    out_en = ctl.clr_evt | ctl.load_evt | (wr_hit & ctl.imm_ok);
    if (ctl.clr_evt)  out_d = '0;
    else if (wr_hit)  out_d = wr_data;
    else              out_d = in_q;
    upd_d  = ~ctl.clr_evt & (ctl.load_evt | (wr_hit & ctl.imm_ok));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_q  <= '0;
      out_q <= '0;
      upd_q <= 1'b0;
    end else begin
      if (in_en)  in_q  <= in_d;
      if (out_en) out_q <= out_d;
      upd_q <= upd_d;
    end
  end

  assign code = out_q;
  assign upd  = upd_q;

endmodule

// File: rtl/chan_code_bank.sv
module chan_code_bank
  import bank_pkg::*;
#(
  parameter int NCH         = 4,
  parameter int DW          = 12,
  parameter int AW          = 3,
  parameter int CH_BASE     = 1,
  parameter int BCAST_ADDR  = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic              load_n,
  input  logic              clear_n,
  output logic [NCH*DW-1:0] code_out,
  output logic [NCH-1:0]    upd_pulse
);

  logic           ld_s, ld_fall;
  logic           clr_s, clr_fall;
  logic [NCH-1:0] hit;
  bank_ctl_t      ctl;

  sync_edge #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_ld_sync (
    .clk(clk), .rst_n(rst_n), .async_in(load_n), .lvl(ld_s), .fell(ld_fall)
  );

  sync_edge #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_clr_sync (
    .clk(clk), .rst_n(rst_n), .async_in(clear_n), .lvl(clr_s), .fell(clr_fall)
  );

  wr_decode #(.NCH(NCH), .AW(AW), .CH_BASE(CH_BASE), .BCAST_ADDR(BCAST_ADDR)) u_dec (
    .wr_en(wr_en), .wr_addr(wr_addr), .hit(hit)
  );

  always_comb begin
    ctl.clr_evt  = clr_fall;
    ctl.load_evt = ld_fall & clr_s;
    ctl.imm_ok   = ~ld_s & clr_s;
  end

  generate
    for (genvar k = 0; k < NCH; k++) begin : g_ch
      chan_slice #(.DW(DW)) u_slice (
        .clk(clk), .rst_n(rst_n), .ctl(ctl), .wr_hit(hit[k]), .wr_data(wr_data),
        .code(code_out[k*DW +: DW]), .upd(upd_pulse[k])
      );
    end
  endgenerate

endmodule

// File: rtl/bank_chk.sv
module bank_chk #(
  parameter int NCH        = 4,
  parameter int DW         = 12,
  parameter int AW         = 3,
  parameter int CH_BASE    = 1,
  parameter int BCAST_ADDR = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [AW-1:0]     wr_addr,
  input logic [DW-1:0]     wr_data,
  input logic [NCH*DW-1:0] code_out,
  input logic [NCH-1:0]    upd_pulse,
  input logic              ld_s,
  input logic              ld_fall,
  input logic              clr_s,
  input logic              clr_fall
);

  localparam logic [AW-1:0] BCAST = AW'(BCAST_ADDR);
  localparam int            LAST  = CH_BASE + NCH - 1;

  logic bad_addr;
  assign bad_addr = (wr_addr != BCAST) &&
                    ((int'(wr_addr) < CH_BASE) || (int'(wr_addr) > LAST));

  assert_reset_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (code_out == '0 && upd_pulse == '0));

  assert_deferred_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && ld_s) |=> (upd_pulse == '0));

  assert_bcast_immediate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == BCAST && !ld_s && clr_s) |=>
      (upd_pulse == '1 && code_out == {NCH{$past(wr_data)}}));

  assert_bad_addr_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && bad_addr && !ld_fall) |=> (upd_pulse == '0));

  assert_load_all_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_fall && clr_s) |=> (upd_pulse == '1));

  assert_clear_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clr_fall |=> (code_out == '0 && upd_pulse == '0));

  assert_clear_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_s && !clr_fall) |=> (upd_pulse == '0 && $stable(code_out)));

  assert_idle_no_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !ld_fall) |=> (upd_pulse == '0));

  assert_change_explained_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(code_out) |-> (upd_pulse != '0 || code_out == '0));

endmodule

bind chan_code_bank bank_chk #(
  .NCH(NCH), .DW(DW), .AW(AW), .CH_BASE(CH_BASE), .BCAST_ADDR(BCAST_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .code_out(code_out), .upd_pulse(upd_pulse), .ld_s(ld_s), .ld_fall(ld_fall),
  .clr_s(clr_s), .clr_fall(clr_fall)
);

// File: tb/sim_chan_code_bank.sv
module sim_chan_code_bank;
  localparam int NCH = 4;
  localparam int DW  = 12;
  localparam int AW  = 3;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              wr_en = 1'b0;
  logic [AW-1:0]     wr_addr = '0;
  logic [DW-1:0]     wr_data = '0;
  logic              load_n = 1'b1;
  logic              clear_n = 1'b1;
  logic [NCH*DW-1:0] code_out;
  logic [NCH-1:0]    upd_pulse;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit m_ldlow = 0;
  bit m_clrlow = 0;
  logic [DW-1:0] m_in  [NCH];
  logic [DW-1:0] m_out [NCH];

  always #5 clk = ~clk;

  chan_code_bank u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .load_n(load_n), .clear_n(clear_n), .code_out(code_out), .upd_pulse(upd_pulse)
  );

  function automatic logic [NCH*DW-1:0] exp_vec();
    logic [NCH*DW-1:0] v;
    for (int k = 0; k < NCH; k++) v[k*DW +: DW] = m_out[k];
    return v;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_outs(input string tag);
    chk(tag, 64'(code_out), 64'(exp_vec()));
  endtask

  // One-cycle write strobe; channel k sits at address k+1, 101 hits all.
  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    logic [NCH-1:0] hitm;
    hitm = '0;
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
    for (int k = 0; k < NCH; k++)
      if (int'(a) == k + 1 || a == 3'd5) hitm[k] = 1'b1;
    for (int k = 0; k < NCH; k++)
      if (hitm[k]) begin
        m_in[k] = d;
        if (m_ldlow && !m_clrlow) m_out[k] = d;
      end
    chk("R2 R3 R4 R6 live codes after write", 64'(code_out), 64'(exp_vec()));
    chk("R10 pulse after write", 64'(upd_pulse),
        64'((m_ldlow && !m_clrlow) ? hitm : '0));
  endtask

  task automatic pulse_load();
    @(negedge clk); load_n = 1'b0;
    @(negedge clk); @(negedge clk);
    chk_outs("R5 no change before third edge");
    chk("R5 no pulse before third edge", 64'(upd_pulse), 64'(0));
    @(negedge clk);
    if (!m_clrlow) for (int k = 0; k < NCH; k++) m_out[k] = m_in[k];
    chk_outs("R5 R8 live codes after load edge");
    chk("R10 R8 pulse on load edge", 64'(upd_pulse), 64'(m_clrlow ? 4'h0 : 4'hF));
    @(negedge clk);
    chk("R10 pulse lasts one cycle", 64'(upd_pulse), 64'(0));
    load_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic hold_load_low();
    @(negedge clk); load_n = 1'b0;
    repeat (4) @(negedge clk);
    if (!m_clrlow) for (int k = 0; k < NCH; k++) m_out[k] = m_in[k];
    m_ldlow = 1;
    chk_outs("R5 R8 live codes after load held low");
  endtask

  task automatic release_load();
    @(negedge clk); load_n = 1'b1;
    repeat (4) @(negedge clk);
    m_ldlow = 0;
  endtask

  task automatic assert_clear();
    @(negedge clk); clear_n = 1'b0;
    @(negedge clk); @(negedge clk);
    chk_outs("R7 no clear before third edge");
    @(negedge clk);
    for (int k = 0; k < NCH; k++) begin m_in[k] = '0; m_out[k] = '0; end
    m_clrlow = 1;
    chk_outs("R7 live codes cleared");
    chk("R10 no pulse on clear", 64'(upd_pulse), 64'(0));
  endtask

  task automatic release_clear();
    @(negedge clk); clear_n = 1'b1;
    repeat (4) @(negedge clk);
    m_clrlow = 0;
    chk_outs("R8 release of clear changes nothing");
  endtask

  function automatic logic [DW-1:0] pat(input int a, input int p);
    return DW'((a * 37 + p * 1031 + 5) % 4096);
  endfunction

  initial begin
    for (int k = 0; k < NCH; k++) begin m_in[k] = '0; m_out[k] = '0; end
    repeat (5) @(negedge clk);
    chk_outs("R1 live codes in reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk_outs("R1 live codes after reset");
    chk("R1 pulses after reset", 64'(upd_pulse), 64'(0));
    pulse_load();  // R1: staging registers also empty

    // Deferred sweep: every address, alternating order, load held high.
    for (int p = 0; p < 4; p++) begin
      for (int i = 0; i < 8; i++) begin
        int a;
        a = (p % 2 == 0) ? i : 7 - i;
        do_write(AW'(a), pat(a, p));
      end
      pulse_load();
    end
    pulse_load();  // R5: repeated edge with no writes keeps codes

    // Immediate sweep: load held low.
    hold_load_low();
    for (int p = 4; p < 6; p++)
      for (int i = 0; i < 8; i++) begin
        int a;
        a = (p % 2 == 0) ? 7 - i : i;
        do_write(AW'(a), pat(a, p));
      end
    release_load();

    // Clear with staged writes and load activity while held.
    do_write(3'd2, 12'h5A5);
    assert_clear();
    do_write(3'd1, 12'h123);
    do_write(3'd4, 12'hFED);
    pulse_load();
    hold_load_low();
    do_write(3'd3, 12'h0F0);
    release_clear();
    release_load();
    pulse_load();

    // R9: write lands on the clock edge where the clear takes effect.
    do_write(3'd5, 12'h777);
    pulse_load();
    @(negedge clk); clear_n = 1'b0;
    @(negedge clk);
    @(negedge clk); wr_en = 1'b1; wr_addr = 3'd1; wr_data = 12'hABC;
    @(negedge clk); wr_en = 1'b0;
    for (int k = 0; k < NCH; k++) begin m_in[k] = '0; m_out[k] = '0; end
    m_clrlow = 1;
    chk_outs("R9 clear wins over same-edge write");
    release_clear();
    pulse_load();
    chk("R9 lost write not staged", 64'(code_out[DW-1:0]), 64'(0));

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog all requirements actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule